// File: doc/BRIEF.md
# Floating-Point Issue Interlock Timer

This block sits at the issue point of a floating-point pipeline. Each cycle it decides whether the operation that is offered may start. It refuses the operation when the execution unit it needs is still inside its repeat interval. It also refuses the operation when one of its source registers is still waiting for a result from an earlier operation. Each operation class carries a fixed pair of values: a result latency, and a repeat interval that is usually one cycle shorter. Square root is the exception. Its length varies with the operand, so it holds its unit and its destination until an external done pulse arrives.

The block holds the following state:
- one repeat countdown per execution unit;
- one ready countdown per architectural register;
- a pending flag and a destination index for the square root in flight.

When a grant is issued, the block loads the countdowns that belong to the accepted operation. No datapath, rounding or exception logic is present.

Top module: `fpu_issue_gate`

## Requirements
- R1: A synchronous reset clears every countdown and any pending square root. On the first cycle after reset, a request of any class is granted.
- R2: `grant` is high only in a cycle where `req_valid` is high and the request is accepted. `stall_why` encodes the outcome: 0 means no request or granted, 1 means the unit is busy, 2 means a source operand is not ready.
- R3: Class code 0 is a register move. It has a latency of 1 and a repeat interval of 1 on its own unit, which is never busy.
- R4: These classes run on the add unit:
  - code 1, add/subtract: latency 4, repeat 3;
  - code 2, compare: latency 3, repeat 2;
  - code 3, negate/absolute value: latency 2, repeat 1.
- R5: These conversion classes run on the add unit:
  - code 9, word to single: latency 6, repeat 5;
  - code 10, word to double: latency 5, repeat 4;
  - code 11, long to single: latency 7, repeat 6;
  - code 12, long to double: latency 4, repeat 3;
  - code 13, single to double: latency 2, repeat 1;
  - code 14, double to single: latency 4, repeat 3;
  - code 15, round/truncate/ceiling/floor/convert to integer: latency 4, repeat 3.
- R6: These classes run on the multiply unit, so a second multiply can start before the first result is ready:
  - code 4, single multiply: latency 7, repeat 3;
  - code 5, double multiply: latency 8, repeat 4.
- R7: These classes run on the divide unit:
  - code 6, single divide: latency 23, repeat 22;
  - code 7, double divide: latency 36, repeat 35.
- R8: Code 8 is square root and runs on the divide unit. The unit is free again in the cycle where `sqrt_done` is high. The destination becomes readable one cycle later. A square root that issues in the same cycle as the done pulse starts a new pending interval.
- R9: Latency L means that an operation issued in cycle t lets a consumer of its destination issue no earlier than cycle t+L. Repeat interval R means that the next operation on the same unit issues no earlier than cycle t+R.
- R10: A busy unit does not block an operation bound for a different unit.
- R11: When a request meets both a busy unit and an unready source, `stall_why` reports the busy unit (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | An operation is offered this cycle |
| req_op | input | 4 | Operation class code (see R3 to R8) |
| req_dst | input | $clog2(NREG) | Destination register index |
| req_src_a | input | $clog2(NREG) | First source register index |
| req_src_b | input | $clog2(NREG) | Second source register index |
| sqrt_done | input | 1 | Completion pulse from the square-root iteration |
| grant | output | 1 | The offered operation issues this cycle |
| stall_why | output | 2 | Refusal reason: 0 none, 1 unit busy, 2 operand not ready |

## Verification
Two events can coincide in one cycle: the square-root done pulse and a new request that depends on that square root. The bench places the pulse in exactly the cycle where a divide-unit request or a consumer of the square-root destination is offered. The unit request must be granted in that cycle, while the consumer must still be refused with reason 2 and granted only one cycle later. A further case issues a second square root in the very cycle of the done pulse. The new destination must then read as not ready, while the old destination becomes readable.

// File: rtl/fpu_issue_gate.sv
module fpu_issue_gate #(
  parameter int NREG = 32,
  parameter int CW   = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [3:0]              req_op,
  input  logic [$clog2(NREG)-1:0] req_dst,
  input  logic [$clog2(NREG)-1:0] req_src_a,
  input  logic [$clog2(NREG)-1:0] req_src_b,
  input  logic                    sqrt_done,
  output logic                    grant,
  output logic [1:0]              stall_why
);
  localparam int RW = $clog2(NREG);
  localparam logic [1:0] U_MOV = 2'd0, U_ADD = 2'd1, U_MUL = 2'd2, U_DIV = 2'd3;
  localparam logic [3:0] OP_SQRT = 4'd8;

  logic [CW-1:0] unit_cnt [4];
  logic [CW-1:0] reg_cnt [NREG];
  logic          sq_pend;
  logic [RW-1:0] sq_dst;

  logic [1:0]    op_unit;
  logic [CW-1:0] op_lat, op_rep;

  // class table: R3..R8
  always_comb begin
    op_unit = U_ADD;
    op_lat  = CW'(4);
    op_rep  = CW'(3);
    case (req_op)
      4'd0:  begin op_unit = U_MOV; op_lat = CW'(1);  op_rep = CW'(1);  end
      4'd2:  begin                  op_lat = CW'(3);  op_rep = CW'(2);  end
      4'd3:  begin                  op_lat = CW'(2);  op_rep = CW'(1);  end
      4'd4:  begin op_unit = U_MUL; op_lat = CW'(7);  op_rep = CW'(3);  end
      4'd5:  begin op_unit = U_MUL; op_lat = CW'(8);  op_rep = CW'(4);  end
      4'd6:  begin op_unit = U_DIV; op_lat = CW'(23); op_rep = CW'(22); end
      4'd7:  begin op_unit = U_DIV; op_lat = CW'(36); op_rep = CW'(35); end
      4'd8:  begin op_unit = U_DIV; op_lat = CW'(1);  op_rep = CW'(1);  end
      4'd9:  begin                  op_lat = CW'(6);  op_rep = CW'(5);  end
      4'd10: begin                  op_lat = CW'(5);  op_rep = CW'(4);  end
      4'd11: begin                  op_lat = CW'(7);  op_rep = CW'(6);  end
      4'd13: begin                  op_lat = CW'(2);  op_rep = CW'(1);  end
      default: ;
    endcase
  end

  wire is_sqrt   = (req_op == OP_SQRT);
  wire unit_busy = (unit_cnt[op_unit] != '0) ||
                   (op_unit == U_DIV && sq_pend && !sqrt_done);
  wire wait_a    = (reg_cnt[req_src_a] != '0) || (sq_pend && sq_dst == req_src_a);
  wire wait_b    = (reg_cnt[req_src_b] != '0) || (sq_pend && sq_dst == req_src_b);

  assign grant     = req_valid && !unit_busy && !wait_a && !wait_b;
  assign stall_why = (!req_valid || grant) ? 2'd0 : (unit_busy ? 2'd1 : 2'd2);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int u = 0; u < 4; u++) unit_cnt[u] <= '0;
      for (int r = 0; r < NREG; r++) reg_cnt[r] <= '0;
      sq_pend <= 1'b0;
      sq_dst  <= '0;
    end else begin
      for (int u = 0; u < 4; u++)
        if (grant && op_unit == 2'(u))  unit_cnt[u] <= op_rep - CW'(1);
        else if (unit_cnt[u] != '0)     unit_cnt[u] <= unit_cnt[u] - CW'(1);
      for (int r = 0; r < NREG; r++)
        if (grant && req_dst == RW'(r)) reg_cnt[r] <= is_sqrt ? '0 : op_lat - CW'(1);
        else if (reg_cnt[r] != '0)      reg_cnt[r] <= reg_cnt[r] - CW'(1);
      if (grant && is_sqrt) begin
        sq_pend <= 1'b1;
        sq_dst  <= req_dst;
      end else if (sqrt_done) begin
        sq_pend <= 1'b0;
      end
    end
  end
endmodule

module fpu_issue_gate_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [3:0] req_op,
  input logic       sqrt_done,
  input logic       grant,
  input logic [1:0] stall_why
);
  wire add_class = req_op inside {4'd1, 4'd2, 4'd3, [4'd9:4'd15]};
  wire div_class = req_op inside {4'd6, 4'd7, 4'd8};

  a_r1_clean_after_reset: assert property (@(posedge clk)
    rst |=> (!req_valid || grant));
  a_r2_grant_needs_request: assert property (@(posedge clk) disable iff (rst)
    grant |-> req_valid);
  a_r2_no_reason_when_free: assert property (@(posedge clk) disable iff (rst)
    (grant || !req_valid) |-> stall_why == 2'd0);
  a_r2_reason_on_refusal: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !grant) |-> (stall_why == 2'd1 || stall_why == 2'd2));
  a_r4_add_spacing: assert property (@(posedge clk) disable iff (rst)
    (grant && req_op == 4'd1) |=> !(grant && add_class));
  a_r6_mul_spacing: assert property (@(posedge clk) disable iff (rst)
    (grant && req_op == 4'd4) |=> !(grant && (req_op == 4'd4 || req_op == 4'd5)));
  a_r7_div_spacing: assert property (@(posedge clk) disable iff (rst)
    (grant && req_op == 4'd6) |=> !(grant && div_class));
  a_r8_sqrt_holds_unit: assert property (@(posedge clk) disable iff (rst)
    (grant && req_op == 4'd8) |=> !(grant && div_class && !sqrt_done));
endmodule

bind fpu_issue_gate fpu_issue_gate_chk chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
  .sqrt_done(sqrt_done), .grant(grant), .stall_why(stall_why)
);

// File: tb/fpu_issue_gate_tb_top.sv
`timescale 1ns/1ps
module fpu_issue_gate_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       req_valid, sqrt_done;
  logic [3:0] req_op;
  logic [4:0] req_dst, req_src_a, req_src_b;
  logic       grant;
  logic [1:0] stall_why;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  fpu_issue_gate dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_dst(req_dst), .req_src_a(req_src_a), .req_src_b(req_src_b),
    .sqrt_done(sqrt_done), .grant(grant), .stall_why(stall_why)
  );

  // {class code, latency, repeat interval}
  localparam logic [15:0] VEC [15] = '{
    {4'd0, 6'd1, 6'd1},   {4'd1, 6'd4, 6'd3},   {4'd2, 6'd3, 6'd2},
    {4'd3, 6'd2, 6'd1},   {4'd4, 6'd7, 6'd3},   {4'd5, 6'd8, 6'd4},
    {4'd6, 6'd23, 6'd22}, {4'd7, 6'd36, 6'd35}, {4'd9, 6'd6, 6'd5},
    {4'd10, 6'd5, 6'd4},  {4'd11, 6'd7, 6'd6},  {4'd12, 6'd4, 6'd3},
    {4'd13, 6'd2, 6'd1},  {4'd14, 6'd4, 6'd3},  {4'd15, 6'd4, 6'd3}
  };

  function automatic string tag_of(input int op);
    if (op == 0) return "R3";
    if (op == 4 || op == 5) return "R6";
    if (op == 6 || op == 7) return "R7";
    if (op >= 9) return "R5";
    return "R4";
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [3:0] op, input logic [4:0] d,
                       input logic [4:0] a, input logic [4:0] b, input logic dn);
    @(negedge clk);
    req_valid = v; req_op = op; req_dst = d; req_src_a = a; req_src_b = b; sqrt_done = dn;
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) drive(1'b0, 4'd0, 5'd0, 5'd0, 5'd0, 1'b0);
  endtask

  task automatic wait_grant(input logic [3:0] op, input logic [4:0] d, input logic [4:0] a,
                            input logic [4:0] b, output int k, output int first_why);
    k = 0; first_why = 0;
    do begin
      k++;
      drive(1'b1, op, d, a, b, 1'b0);
      if (!grant && first_why == 0) first_why = int'(stall_why);
    end while (!grant && k < 200);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k, fw, dl;
    rst = 1'b1; req_valid = 0; req_op = 0; req_dst = 0; req_src_a = 0; req_src_b = 0; sqrt_done = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);
    check("R2", int'(grant), 0, "grant without request");
    check("R2", int'(stall_why), 0, "reason without request");

    // table walk: repeat interval and latency of every fixed class (R9)
    for (int i = 0; i < 15; i++) begin
      logic [3:0] op;
      int lat, rep;
      op  = VEC[i][15:12];
      lat = int'(VEC[i][11:6]);
      rep = int'(VEC[i][5:0]);
      idle(40);
      drive(1'b1, op, 5'd5, 5'd0, 5'd1, 1'b0);
      check(tag_of(int'(op)), int'(grant), 1, "first issue");
      wait_grant(op, 5'd6, 5'd10, 5'd11, k, fw);
      check(tag_of(int'(op)), k, rep, "repeat interval (R9)");
      if (rep > 1) check("R2", fw, 1, "reason while unit busy");
      idle(40);
      drive(1'b1, op, 5'd5, 5'd0, 5'd1, 1'b0);
      wait_grant(4'd0, 5'd31, 5'd5, 5'd0, k, fw);
      check(tag_of(int'(op)), k, lat, "latency (R9)");
      if (lat > 1) check("R9", fw, 2, "reason while operand pending");
    end

    // square root with done pulses at the range edges and a random length
    for (int t = 0; t < 4; t++) begin
      dl = (t == 0) ? 2 : (t == 1) ? 54 : (t == 2) ? 112 : int'($urandom_range(3, 111));
      idle(40);
      drive(1'b1, 4'd8, 5'd7, 5'd0, 5'd1, 1'b0);
      check("R8", int'(grant), 1, "sqrt issue");
      for (int j = 1; j <= dl - 1; j++) begin
        drive(1'b1, 4'd6, 5'd8, 5'd0, 5'd1, j == dl - 1);
        if (j == 1 && dl > 2) check("R8", int'(stall_why), 1, "divide unit held by sqrt");
        if (j == dl - 1) check("R8", int'(grant), 1, "unit free in done cycle");
      end
      idle(40);
      drive(1'b1, 4'd8, 5'd7, 5'd0, 5'd1, 1'b0);
      for (int j = 1; j <= dl; j++) begin
        drive(1'b1, 4'd0, 5'd31, 5'd7, 5'd0, j == dl - 1);
        if (j == dl - 1) check("R8", int'(stall_why), 2, "consumer still waits in done cycle");
        if (j == dl) check("R8", int'(grant), 1, "consumer issues after done");
      end
    end

    // new sqrt in the done cycle of the previous one
    idle(40);
    drive(1'b1, 4'd8, 5'd7, 5'd0, 5'd1, 1'b0);
    drive(1'b1, 4'd8, 5'd12, 5'd0, 5'd1, 1'b1);
    check("R8", int'(grant), 1, "sqrt issues in done cycle");
    drive(1'b1, 4'd0, 5'd31, 5'd12, 5'd0, 1'b0);
    check("R8", int'(stall_why), 2, "new sqrt destination pending");
    drive(1'b1, 4'd0, 5'd31, 5'd7, 5'd0, 1'b0);
    check("R8", int'(grant), 1, "old sqrt destination ready");
    drive(1'b0, 4'd0, 5'd0, 5'd0, 5'd0, 1'b1);

    // busy unit and unready source together
    idle(40);
    drive(1'b1, 4'd5, 5'd3, 5'd0, 5'd1, 1'b0);
    drive(1'b1, 4'd4, 5'd20, 5'd3, 5'd0, 1'b0);
    check("R11", int'(stall_why), 1, "busy reported over hazard");

    // units independent
    idle(40);
    drive(1'b1, 4'd7, 5'd4, 5'd0, 5'd1, 1'b0);
    drive(1'b1, 4'd1, 5'd21, 5'd0, 5'd1, 1'b0);
    check("R10", int'(grant), 1, "add while divide busy");
    drive(1'b1, 4'd4, 5'd22, 5'd0, 5'd1, 1'b0);
    check("R10", int'(grant), 1, "multiply while divide busy");

    // reset clears pending state
    idle(40);
    drive(1'b1, 4'd7, 5'd9, 5'd0, 5'd1, 1'b0);
    @(negedge clk) rst = 1'b1; req_valid = 1'b0;
    @(negedge clk) rst = 1'b0;
    drive(1'b1, 4'd7, 5'd23, 5'd9, 5'd0, 1'b0);
    check("R1", int'(grant), 1, "divide after reset");

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule